// File: doc/BRIEF.md
# Redundant-Thread Committed Store Comparator

This block checks two redundant copies of one program by comparing the stores that each copy commits. The leading thread and the trailing thread each hand their committed stores (address and data) to a private in-order queue. Every queued store carries the value of a free-running cycle counter taken on the cycle it was accepted. Whenever both queue heads hold a store, the two heads are removed together and compared. Any difference in address or data raises a fault flag, which stays set until software-side logic clears it.

A queue that is full refuses further stores through its ready output, so commit of a store in that thread stalls until the partner thread catches up. Each compared pair is also timed. The pair is a lead when the trailing thread's store was accepted on an earlier cycle than the leading thread's store. In every other case it is a lag. The block counts lead pairs and lag pairs and keeps the largest lag seen, in cycles. Recovery and the actual memory write are left to other logic.

Top module: `store_pair_checker`

## Requirements
- R1: Each thread's stores leave its queue in the order they were accepted, and each store carries the 32-bit cycle stamp of the cycle on which its push was accepted.
- R2: A comparison happens only in a cycle where both queue heads hold a store, and then both heads are removed together; a store with no partner waits and is not counted.
- R3: A queue holding DEPTH (default 16) stores drives its ready output low, and a push offered while ready is low is discarded.
- R4: A compared pair whose addresses differ, or whose data differ, sets `fault` on the following clock edge.
- R5: `fault` stays set until `fault_clr` is high; when a clear and a mismatching comparison fall in the same cycle, `fault` ends up set.
- R6: A pair whose trailing stamp is earlier than its leading stamp increments `lead_cnt`; any other pair, including equal stamps, increments `lag_cnt`.
- R7: `max_lag` holds the largest value of (trailing stamp minus leading stamp) over all lag pairs. Slack is computed modulo 2^32, so a lag of about a million cycles is reported exactly.
- R8: After reset, `fault` is 0, both counters and `max_lag` are 0, and both ready outputs are 1.
- R9: If the later store of a pair is pushed in cycle c, the counters and `fault` show that pair after the clock edge that ends cycle c+1, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_push | input | 1 | Leading thread offers a committed store |
| m_addr | input | ADDR_W | Leading thread store address |
| m_data | input | DATA_W | Leading thread store data |
| m_ready | output | 1 | Leading queue can accept a store |
| r_push | input | 1 | Trailing thread offers a committed store |
| r_addr | input | ADDR_W | Trailing thread store address |
| r_data | input | DATA_W | Trailing thread store data |
| r_ready | output | 1 | Trailing queue can accept a store |
| fault_clr | input | 1 | Clears the sticky fault flag |
| fault | output | 1 | Sticky mismatch flag |
| lead_cnt | output | CNT_W | Number of lead pairs |
| lag_cnt | output | CNT_W | Number of lag pairs |
| max_lag | output | 32 | Largest lag slack seen, in cycles |

## Verification
The clearing of the sticky fault flag and the setting of it by a new mismatch can fall in the same cycle. The bench first leaves `fault` set. It then pushes a mismatching pair in one cycle and raises `fault_clr` in exactly the next cycle, which is the cycle in which that pair is compared. It expects `fault` to read 1 afterwards, and 0 only after a later clear with no comparison pending. A second overlap occurs when a full queue refuses a push while the partner thread drains it. The bench judges this overlap by which partner the next trailing store finds.

// File: rtl/spc_pkg.sv
package spc_pkg;

  localparam int STAMP_W = 32;
  typedef logic [STAMP_W-1:0] stamp_t;

  // signed distance from leading stamp to trailing stamp, modulo 2^STAMP_W
  function automatic stamp_t slack_of(input stamp_t lead_ts, input stamp_t trail_ts);
    return trail_ts - lead_ts;
  endfunction

  // trailing store committed strictly earlier than its partner
  function automatic logic trail_is_early(input stamp_t lead_ts, input stamp_t trail_ts);
    stamp_t d;
    d = slack_of(lead_ts, trail_ts);
    return d[STAMP_W-1];
  endfunction

endpackage

// File: rtl/spc_timebase.sv
module spc_timebase #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] stamp
);
  always_ff @(posedge clk) begin
    if (!rst_n) stamp <= '0;
    else        stamp <= stamp + 1'b1;
  end
endmodule

// File: rtl/spc_fifo.sv
module spc_fifo #(
  parameter int W     = 96,
  parameter int DEPTH = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  output logic          ready,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          valid,
  output logic [LW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          full, do_push, do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (level == LW'(DEPTH));
  assign ready   = !full;
  assign valid   = (level != '0);
  assign do_push = push && !full;
  assign do_pop  = pop && valid;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/spc_judge.sv
module spc_judge #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fire,
  input  logic [ADDR_W-1:0]      m_addr,
  input  logic [DATA_W-1:0]      m_data,
  input  spc_pkg::stamp_t        m_ts,
  input  logic [ADDR_W-1:0]      r_addr,
  input  logic [DATA_W-1:0]      r_data,
  input  spc_pkg::stamp_t        r_ts,
  input  logic                   fault_clr,
  output logic                   mismatch,
  output logic                   lead_evt,
  output logic                   lag_evt,
  output logic                   fault,
  output logic [CNT_W-1:0]       lead_cnt,
  output logic [CNT_W-1:0]       lag_cnt,
  output spc_pkg::stamp_t        max_lag
);
  spc_pkg::stamp_t slack;
  logic            early;

  assign slack    = spc_pkg::slack_of(m_ts, r_ts);
  assign early    = spc_pkg::trail_is_early(m_ts, r_ts);
  assign mismatch = fire && ((m_addr != r_addr) || (m_data != r_data));
  assign lead_evt = fire && early;
  assign lag_evt  = fire && !early;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault    <= 1'b0;
      lead_cnt <= '0;
      lag_cnt  <= '0;
      max_lag  <= '0;
    end else begin
      fault <= (fault && !fault_clr) || mismatch;
      if (lead_evt) lead_cnt <= lead_cnt + 1'b1;
      if (lag_evt) begin
        lag_cnt <= lag_cnt + 1'b1;
        if (slack > max_lag) max_lag <= slack;
      end
    end
  end
endmodule

// File: rtl/store_pair_checker.sv
module store_pair_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                m_push,
  input  logic [ADDR_W-1:0]   m_addr,
  input  logic [DATA_W-1:0]   m_data,
  output logic                m_ready,
  input  logic                r_push,
  input  logic [ADDR_W-1:0]   r_addr,
  input  logic [DATA_W-1:0]   r_data,
  output logic                r_ready,
  input  logic                fault_clr,
  output logic                fault,
  output logic [CNT_W-1:0]    lead_cnt,
  output logic [CNT_W-1:0]    lag_cnt,
  output logic [31:0]         max_lag
);
  localparam int SW    = spc_pkg::STAMP_W;
  localparam int EW    = SW + ADDR_W + DATA_W;
  localparam int LVL_W = $clog2(DEPTH + 1);

  spc_pkg::stamp_t    stamp;
  logic [EW-1:0]      m_head, r_head;
  logic               m_valid, r_valid;
  logic [LVL_W-1:0]   m_level, r_level;

  // named internal events for the bound checker
  logic cmp_fire, cmp_mismatch, cmp_lead, cmp_lag;

  spc_timebase #(.W(SW)) u_time (
    .clk(clk), .rst_n(rst_n), .stamp(stamp)
  );

  spc_fifo #(.W(EW), .DEPTH(DEPTH)) u_mq (
    .clk(clk), .rst_n(rst_n), .push(m_push), .din({stamp, m_addr, m_data}),
    .ready(m_ready), .pop(cmp_fire), .dout(m_head), .valid(m_valid), .level(m_level)
  );

  spc_fifo #(.W(EW), .DEPTH(DEPTH)) u_rq (
    .clk(clk), .rst_n(rst_n), .push(r_push), .din({stamp, r_addr, r_data}),
    .ready(r_ready), .pop(cmp_fire), .dout(r_head), .valid(r_valid), .level(r_level)
  );

  assign cmp_fire = m_valid && r_valid;

  spc_judge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_judge (
    .clk(clk), .rst_n(rst_n), .fire(cmp_fire),
    .m_addr(m_head[DATA_W +: ADDR_W]), .m_data(m_head[DATA_W-1:0]),
    .m_ts(m_head[EW-1 -: SW]),
    .r_addr(r_head[DATA_W +: ADDR_W]), .r_data(r_head[DATA_W-1:0]),
    .r_ts(r_head[EW-1 -: SW]),
    .fault_clr(fault_clr), .mismatch(cmp_mismatch), .lead_evt(cmp_lead),
    .lag_evt(cmp_lag), .fault(fault), .lead_cnt(lead_cnt), .lag_cnt(lag_cnt),
    .max_lag(max_lag)
  );
endmodule

// File: rtl/spc_checker.sv
module spc_checker #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 32,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fault,
  input logic             fault_clr,
  input logic [CNT_W-1:0] lead_cnt,
  input logic [CNT_W-1:0] lag_cnt,
  input logic [31:0]      max_lag,
  input logic             fire,
  input logic             mismatch,
  input logic             lead_evt,
  input logic             lag_evt,
  input logic [LVL_W-1:0] m_level,
  input logic [LVL_W-1:0] r_level,
  input logic             m_ready,
  input logic             m_push
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_level <= LVL_W'(DEPTH)) && (r_level <= LVL_W'(DEPTH)));

  assert_refused_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!m_ready && m_push && !fire) |=> $stable(m_level));

  assert_pair_heads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (m_level != '0) && (r_level != '0));

  assert_one_class_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({lead_evt, lag_evt}) == (fire ? 1 : 0));

  assert_lag_counted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lag_evt |=> lag_cnt == $past(lag_cnt) + 1'b1);

  assert_lead_counted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lead_evt |=> lead_cnt == $past(lead_cnt) + 1'b1);

  assert_mismatch_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> fault);

  assert_fault_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !fault_clr) |=> fault);

  assert_clear_works_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_clr && !mismatch) |=> !fault);

  assert_max_grows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> max_lag >= $past(max_lag));
endmodule

bind store_pair_checker spc_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fault(fault), .fault_clr(fault_clr),
  .lead_cnt(lead_cnt), .lag_cnt(lag_cnt), .max_lag(max_lag),
  .fire(cmp_fire), .mismatch(cmp_mismatch), .lead_evt(cmp_lead), .lag_evt(cmp_lag),
  .m_level(m_level), .r_level(r_level), .m_ready(m_ready), .m_push(m_push)
);

// File: tb/sim_store_pair_checker.sv
module sim_store_pair_checker;
  localparam int CLK_P = 10;
  localparam int DEPTH = 16;
  localparam int NV    = 6;
  // gap: cycles from leading push to trailing push (negative: trailing first)
  localparam int VGAP [NV] = '{0, 5, -3, 12, -1, 40};
  // corruption: 0 none, 1 data, 2 address
  localparam int VBAD [NV] = '{0, 0, 0, 1, 2, 0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_push = 0, r_push = 0, fault_clr = 0;
  logic [31:0] m_addr = 0, m_data = 0, r_addr = 0, r_data = 0;
  logic m_ready, r_ready, fault;
  logic [31:0] lead_cnt, lag_cnt, max_lag;

  int errors = 0, checks = 0;
  int exp_lead = 0, exp_lag = 0, exp_max = 0;
  bit done = 0;

  store_pair_checker u0 (
    .clk(clk), .rst_n(rst_n), .m_push(m_push), .m_addr(m_addr), .m_data(m_data),
    .m_ready(m_ready), .r_push(r_push), .r_addr(r_addr), .r_data(r_data),
    .r_ready(r_ready), .fault_clr(fault_clr), .fault(fault), .lead_cnt(lead_cnt),
    .lag_cnt(lag_cnt), .max_lag(max_lag)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one cycle of stimulus, driven at a falling edge
  task automatic cyc(input bit mp, input logic [31:0] ma, input logic [31:0] md,
                     input bit rp, input logic [31:0] ra, input logic [31:0] rd);
    m_push = mp; m_addr = ma; m_data = md;
    r_push = rp; r_addr = ra; r_data = rd;
    @(negedge clk);
    m_push = 0; r_push = 0;
  endtask

  task automatic clear_fault();
    fault_clr = 1;
    @(negedge clk);
    fault_clr = 0;
  endtask

  task automatic check_stats(input string tag);
    chk({tag, " R6 lead_cnt"}, lead_cnt, exp_lead);
    chk({tag, " R6 lag_cnt"}, lag_cnt, exp_lag);
    chk({tag, " R7 max_lag"}, max_lag, exp_max);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    // R8 reset state
    chk("R8 fault", fault, 0);
    chk("R8 lead_cnt", lead_cnt, 0);
    chk("R8 lag_cnt", lag_cnt, 0);
    chk("R8 max_lag", max_lag, 0);
    chk("R8 m_ready", m_ready, 1);
    chk("R8 r_ready", r_ready, 1);

    // table walk: R1 stamping, R4 detection, R6/R7 classification
    for (int v = 0; v < NV; v++) begin
      logic [31:0] a, d, ra, rd;
      int g;
      g  = VGAP[v];
      a  = 32'h1000 + v;
      d  = 32'hA500 + v;
      ra = (VBAD[v] == 2) ? a ^ 32'h10 : a;
      rd = (VBAD[v] == 1) ? d ^ 32'h1 : d;
      if (g == 0) cyc(1, a, d, 1, ra, rd);
      else if (g > 0) begin
        cyc(1, a, d, 0, 0, 0); step(g - 1); cyc(0, 0, 0, 1, ra, rd);
      end else begin
        cyc(0, 0, 0, 1, ra, rd); step(-g - 1); cyc(1, a, d, 0, 0, 0);
      end
      step(2);
      if (g < 0) exp_lead++;
      else begin
        exp_lag++;
        if (g > exp_max) exp_max = g;
      end
      check_stats($sformatf("R1 vec%0d", v));
      chk($sformatf("R4 vec%0d fault", v), fault, (VBAD[v] != 0) ? 1 : 0);
      if (fault) clear_fault();
    end

    // R3: fill the leading queue, offer one refused store
    for (int i = 0; i < DEPTH; i++) cyc(1, 32'h2000 + i, 32'hB000 + i, 0, 0, 0);
    chk("R3 m_ready low when full", m_ready, 0);
    cyc(1, 32'h2000 + DEPTH, 32'hDEAD, 0, 0, 0);
    chk("R3 m_ready still low", m_ready, 0);
    for (int i = 0; i < DEPTH; i++) cyc(0, 0, 0, 1, 32'h2000 + i, 32'hB000 + i);
    step(2);
    exp_lag += DEPTH;
    if (DEPTH + 1 > exp_max) exp_max = DEPTH + 1;
    check_stats("R3 drain");
    chk("R3 drain fault", fault, 0);
    chk("R3 m_ready back", m_ready, 1);
    // R2: a lone trailing store that would match the refused one must wait
    cyc(0, 0, 0, 1, 32'h2000 + DEPTH, 32'hDEAD);
    step(3);
    check_stats("R2 lone store waits");
    cyc(1, 32'h2000 + DEPTH, 32'hDEAD, 0, 0, 0);
    step(2);
    exp_lead++;
    check_stats("R2 partner arrives");
    chk("R2 fault", fault, 0);

    // R3: fill the trailing queue
    for (int i = 0; i < DEPTH; i++) cyc(0, 0, 0, 1, 32'h3000 + i, 32'hC000 + i);
    chk("R3 r_ready low when full", r_ready, 0);
    for (int i = 0; i < DEPTH; i++) cyc(1, 32'h3000 + i, 32'hC000 + i, 0, 0, 0);
    step(2);
    exp_lead += DEPTH;
    check_stats("R3 trailing drain");
    chk("R3 r_ready back", r_ready, 1);

    // R5: clear and new mismatch in the same cycle
    cyc(1, 32'h4000, 32'h1, 1, 32'h4000, 32'h2);
    step(2);
    exp_lag++;
    chk("R5 fault set", fault, 1);
    cyc(1, 32'h4001, 32'h3, 1, 32'h4001, 32'h4);
    clear_fault();          // this cycle compares the second mismatching pair
    exp_lag++;
    chk("R5 set wins over clear", fault, 1);
    step(2);
    chk("R5 sticky", fault, 1);
    clear_fault();
    chk("R5 cleared", fault, 0);
    check_stats("R5 stats");

    // R7/R9: long lag, exact update cycle
    cyc(1, 32'h5000, 32'h77, 0, 0, 0);
    step(999);
    cyc(0, 0, 0, 1, 32'h5000, 32'h77);
    chk("R9 not yet counted", lag_cnt, exp_lag);
    step(1);
    exp_lag++;
    exp_max = 1000;
    chk("R9 counted next edge", lag_cnt, exp_lag);
    chk("R7 long lag", max_lag, 1000);
    chk("R7 fault", fault, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule